// File: doc/BRIEF.md
# Dual-Mode Per-Processor Timer

This block is the counter/timer that sits beside one processor. A mode input, driven from a system configuration register outside the block, picks one of two personalities. In counter mode the timer counts prescaled ticks up to a programmable limit, wraps, flags the event and raises a local interrupt. Software acknowledges the interrupt by reading the limit word. In user-timer mode the same storage becomes a 63-bit up-counter that software can start, stop and load in two 32-bit halves. It stops at its maximum value and never interrupts.

All values on the bus are byte-scaled: bits 8:0 of every count and limit word read as zero, so one tick adds 0x200. The tick prescaler is outside the block and arrives as a one-cycle `tick` qualifier. When the mode input changes, the change forces the running state, the limit and the count in a defined way. The four-word register window is decoded differently in each mode.

Top module: `dual_timer`

## Requirements
- R1: After reset the block is in counter mode with limit 0, count 0, reached flag 0, interrupt low, and word 3 reading 1 (running).
- R2: In counter mode each tick adds one to the count. With limit field L = word0 bits 30:9 non-zero, the count runs 0..L-1, and the tick after L-1 returns it to 0 and sets both the reached flag (word 1 bit 31) and `irq`. With L = 0 the counter runs freely over its whole 22-bit range.
- R3: In counter mode, a write to word 0 loads the limit and clears the count, the reached flag and `irq`. A write to word 2 loads the limit in either mode and leaves the count untouched.
- R4: In counter mode, reading word 0 returns the limit in bits 30:9 and clears the reached flag and `irq` on that clock.
- R5: In counter mode, writes to word 1 and word 3 change nothing, and word 3 always reads 1.
- R6: In user mode, word 0 reads {reached, count bits 62:32} and word 1 reads count bits 31:9 in bits 31:9, with zeros below. Word 2 reads 0 in both modes.
- R7: In user mode, a write to word 0 loads count bits 62:32 from wdata bits 30:0, and a write to word 1 loads count bits 31:9 from wdata bits 31:9. Each of these writes clears the reached flag.
- R8: In user mode, writing word 3 with bit 0 set starts the count and writing it with bit 0 clear stops it. A stopped count ignores ticks, and word 3 bit 0 reads the running state.
- R9: In user mode the count stops at 0x7FFFFFFFFFFFFE00 with the reached flag set, until software reloads it, and `irq` stays low throughout.
- R10: On the clock where the sampled mode changes from counter to user, `irq` drops, running clears and the limit becomes 0, while the count and the reached flag are kept.
- R11: On the clock where the sampled mode changes from user to counter, running becomes 1 and the count and the reached flag clear.
- R12: A mode change outranks a bus write and a tick in the same clock, and a bus write outranks a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle count qualifier from the external prescaler |
| user_mode | input | 1 | 1 selects user-timer mode, 0 selects counter mode |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word index 0..3 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word (combinational) |
| irq | output | 1 | Local interrupt, counter mode only |

## Verification
The assertions assume that `user_mode` is synchronous to `clk`, or that a synchronizer is selected by parameter. They also assume that `tick` and bus strobes are qualified by the clock edge alone, so each input value counts in exactly one cycle. The stimulus changes every input half a period away from the rising edge and holds it for a full cycle. It deliberately places mode changes in the same cycle as writes and ticks to check the priority rule. The 63-bit saturation point is reached by loading a count two ticks below it, rather than by counting up to it.

// File: rtl/dual_timer_pkg.sv
`timescale 1ns/1ps
package dual_timer_pkg;
   localparam int WORD_AW = 2;
   // register window word index, decode depends on mode
   typedef enum logic [WORD_AW-1:0] {
      W_HI_LIM   = 2'd0,
      W_LO_CNT   = 2'd1,
      W_LIM_KEEP = 2'd2,
      W_CTRL     = 2'd3
   } word_e;
endpackage

// File: rtl/dual_timer_mode.sv
`timescale 1ns/1ps
module dual_timer_mode #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic user_mode,
   output logic mode_user,
   output logic enter_user,
   output logic leave_user
);
   logic samp;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign samp = user_mode;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[SYNC_STAGES-2+1-1:0], user_mode} >> 0;
         end
         assign samp = chain_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mode_user <= 1'b0;
      else        mode_user <= samp;
   end

   assign enter_user = samp & ~mode_user;
   assign leave_user = ~samp & mode_user;
endmodule

// File: rtl/dual_timer_core.sv
`timescale 1ns/1ps
module dual_timer_core
   import dual_timer_pkg::*;
#(
   parameter int FRAC_W = 9,
   parameter int SYS_W  = 31,
   parameter int USER_W = 63,
   parameter int DATA_W = 32
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      is_user,
   input  logic                      enter_user,
   input  logic                      leave_user,
   input  logic                      tick,
   input  logic                      wr_en,
   input  logic                      rd_en,
   input  word_e                     addr,
   input  logic [DATA_W-1:0]         wdata,
   output logic [USER_W-FRAC_W-1:0]  cnt_q,
   output logic [SYS_W-FRAC_W-1:0]   lim_q,
   output logic                      reached_q,
   output logic                      irq_q,
   output logic                      run_q
);
   localparam int SYS_P = SYS_W - FRAC_W;
   localparam int USR_P = USER_W - FRAC_W;
   localparam int LO_P  = DATA_W - FRAC_W;

   logic [SYS_P-1:0] term_m1;
   logic [USR_P-1:0] cnt_inc;
   logic             sys_wrap;

   always_comb begin
      term_m1  = (lim_q == '0) ? '1 : lim_q - 1'b1;
      sys_wrap = cnt_q[SYS_P-1:0] >= term_m1;
      cnt_inc  = cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         lim_q     <= '0;
         reached_q <= 1'b0;
         irq_q     <= 1'b0;
         run_q     <= 1'b1;
      end else if (enter_user) begin
         irq_q <= 1'b0;
         run_q <= 1'b0;
         lim_q <= '0;
      end else if (leave_user) begin
         run_q     <= 1'b1;
         cnt_q     <= '0;
         reached_q <= 1'b0;
      end else if (wr_en) begin
         unique case (addr)
            W_HI_LIM: begin
               if (is_user) begin
                  cnt_q[USR_P-1:LO_P] <= wdata[USR_P-LO_P-1:0];
               end else begin
                  lim_q <= wdata[SYS_W-1:FRAC_W];
                  cnt_q <= '0;
                  irq_q <= 1'b0;
               end
               reached_q <= 1'b0;
            end
            W_LO_CNT: begin
               if (is_user) begin
                  cnt_q[LO_P-1:0] <= wdata[DATA_W-1:FRAC_W];
                  reached_q       <= 1'b0;
               end
            end
            W_LIM_KEEP: lim_q <= wdata[SYS_W-1:FRAC_W];
            W_CTRL:     if (is_user) run_q <= wdata[0];
            default: ;
         endcase
      end else begin
         if (rd_en && addr == W_HI_LIM && !is_user) begin
            reached_q <= 1'b0;
            irq_q     <= 1'b0;
         end
         if (tick) begin
            if (!is_user) begin
               if (sys_wrap) begin
                  cnt_q     <= '0;
                  reached_q <= 1'b1;
                  irq_q     <= 1'b1;
               end else begin
                  cnt_q <= cnt_inc;
               end
            end else if (run_q) begin
               if (&cnt_q) begin
                  reached_q <= 1'b1;
               end else begin
                  cnt_q <= cnt_inc;
                  if (&cnt_inc) reached_q <= 1'b1;
               end
            end
         end
      end
   end
endmodule

// File: rtl/dual_timer_rdmux.sv
`timescale 1ns/1ps
module dual_timer_rdmux
   import dual_timer_pkg::*;
#(
   parameter int FRAC_W = 9,
   parameter int SYS_W  = 31,
   parameter int USER_W = 63,
   parameter int DATA_W = 32
) (
   input  logic                     is_user,
   input  word_e                    addr,
   input  logic [USER_W-FRAC_W-1:0] cnt_q,
   input  logic [SYS_W-FRAC_W-1:0]  lim_q,
   input  logic                     reached_q,
   input  logic                     run_q,
   output logic [DATA_W-1:0]        rdata
);
   localparam int SYS_P = SYS_W - FRAC_W;
   localparam int USR_P = USER_W - FRAC_W;
   localparam int LO_P  = DATA_W - FRAC_W;
   localparam int HI_P  = USR_P - LO_P;

   always_comb begin
      rdata = '0;
      unique case (addr)
         W_HI_LIM: begin
            if (is_user) begin
               rdata[HI_P-1:0]   = cnt_q[USR_P-1:LO_P];
               rdata[DATA_W-1]   = reached_q;
            end else begin
               rdata[SYS_W-1:FRAC_W] = lim_q;
            end
         end
         W_LO_CNT: begin
            if (is_user) begin
               rdata[DATA_W-1:FRAC_W] = cnt_q[LO_P-1:0];
            end else begin
               rdata[SYS_W-1:FRAC_W] = cnt_q[SYS_P-1:0];
               rdata[DATA_W-1]       = reached_q;
            end
         end
         W_CTRL:  rdata[0] = run_q;
         default: rdata = '0;
      endcase
   end
endmodule

// File: rtl/dual_timer.sv
`timescale 1ns/1ps
module dual_timer
   import dual_timer_pkg::*;
#(
   parameter int FRAC_W      = 9,
   parameter int SYS_W       = 31,
   parameter int USER_W      = 63,
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               user_mode,
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic [1:0]         bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic               irq
);
   localparam int SYS_P = SYS_W - FRAC_W;
   localparam int USR_P = USER_W - FRAC_W;

   generate
      if (SYS_W > DATA_W - 1) begin : g_bad_sys
         $error("SYS_W must leave the top data bit for the reached flag");
      end
      if (USER_W <= DATA_W || USER_W > 2*DATA_W - 1) begin : g_bad_user
         $error("USER_W must span two words with the top bit free");
      end
      if (FRAC_W < 1 || FRAC_W >= SYS_W) begin : g_bad_frac
         $error("FRAC_W out of range");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
         $error("SYNC_STAGES must be 0..3");
      end
   endgenerate

   logic             mode_user, enter_user, leave_user, mode_chg;
   logic             wr_en, rd_en;
   logic [USR_P-1:0] cnt_q;
   logic [SYS_P-1:0] lim_q;
   logic             reached_q, run_q;
   word_e            addr;

   assign wr_en    = bus_sel & bus_wr;
   assign rd_en    = bus_sel & ~bus_wr;
   assign addr     = word_e'(bus_addr);
   assign mode_chg = enter_user | leave_user;

   dual_timer_mode #(.SYNC_STAGES(SYNC_STAGES)) u_mode (
      .clk(clk), .rst_n(rst_n), .user_mode(user_mode),
      .mode_user(mode_user), .enter_user(enter_user), .leave_user(leave_user)
   );

   dual_timer_core #(.FRAC_W(FRAC_W), .SYS_W(SYS_W), .USER_W(USER_W), .DATA_W(DATA_W)) u_core (
      .clk(clk), .rst_n(rst_n), .is_user(mode_user),
      .enter_user(enter_user), .leave_user(leave_user), .tick(tick),
      .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(bus_wdata),
      .cnt_q(cnt_q), .lim_q(lim_q), .reached_q(reached_q), .irq_q(irq), .run_q(run_q)
   );

   dual_timer_rdmux #(.FRAC_W(FRAC_W), .SYS_W(SYS_W), .USER_W(USER_W), .DATA_W(DATA_W)) u_rd (
      .is_user(mode_user), .addr(addr), .cnt_q(cnt_q), .lim_q(lim_q),
      .reached_q(reached_q), .run_q(run_q), .rdata(bus_rdata)
   );
endmodule

// File: rtl/dual_timer_chk.sv
`timescale 1ns/1ps
module dual_timer_chk #(
   parameter int USR_P = 54
) (
   input logic             clk,
   input logic             rst_n,
   input logic             is_user,
   input logic             irq,
   input logic             run_q,
   input logic [USR_P-1:0] cnt_q,
   input logic             reached_q,
   input logic             wr_en,
   input logic             mode_chg,
   input logic [1:0]       addr
);
   // R9
   user_irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_user |-> !irq);

   // R10
   enter_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(is_user) |-> (!run_q && !irq));

   // R11
   leave_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(is_user) |-> (run_q && cnt_q == '0 && !reached_q));

   // R5
   sys_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !is_user |-> run_q);

   // R9
   user_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (is_user && (&cnt_q) && !wr_en && !mode_chg) |=> ((&cnt_q) && reached_q));

   // R5
   ctrl_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_user && wr_en && addr == 2'd3 && !mode_chg) |=> ($stable(cnt_q) && run_q));
endmodule

bind dual_timer dual_timer_chk #(.USR_P(USER_W - FRAC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .is_user(mode_user), .irq(irq), .run_q(run_q),
   .cnt_q(cnt_q), .reached_q(reached_q), .wr_en(wr_en), .mode_chg(mode_chg),
   .addr(bus_addr)
);

// File: tb/dual_timer_test.sv
`timescale 1ns/1ps
module dual_timer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0, user_mode = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int total = 0;
   int bad = 0;
   string cur_req = "R1";
   bit um = 1'b0;

   localparam logic [63:0] SYS_MAX = 64'h3F_FFFF;
   localparam logic [63:0] USR_MAX = (64'd1 << 54) - 1;
   localparam logic [63:0] LOMASK  = 64'h7F_FFFF;

   logic [63:0] m_cnt, m_lim;
   bit m_user, m_reached, m_irq, m_run;

   always #2.5 clk = ~clk;

   dual_timer uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .user_mode(user_mode),
      .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   function automatic logic [31:0] model_read(input logic [1:0] a);
      logic [63:0] r;
      case (a)
         2'd0: r = m_user ? ((64'(m_reached) << 31) | (m_cnt >> 23)) : (m_lim << 9);
         2'd1: r = m_user ? ((m_cnt & LOMASK) << 9) : ((64'(m_reached) << 31) | (m_cnt << 9));
         2'd3: r = 64'(m_run);
         default: r = '0;
      endcase
      return r[31:0];
   endfunction

   task automatic model_update(input bit s, input bit w, input logic [1:0] a,
                               input logic [31:0] d, input bit t);
      logic [63:0] dd, tm1;
      dd = 64'(d);
      if (um != m_user) begin
         if (um) begin m_irq = 0; m_run = 0; m_lim = '0; end
         else begin m_run = 1; m_cnt = '0; m_reached = 0; end
         m_user = um;
      end else if (s && w) begin
         case (a)
            2'd0: if (m_user) begin
                     m_cnt = (m_cnt & LOMASK) | ((dd & 64'h7FFF_FFFF) << 23); m_reached = 0;
                  end else begin
                     m_lim = (dd >> 9) & SYS_MAX; m_cnt = '0; m_reached = 0; m_irq = 0;
                  end
            2'd1: if (m_user) begin
                     m_cnt = (m_cnt & ~LOMASK) | ((dd >> 9) & LOMASK); m_reached = 0;
                  end
            2'd2: m_lim = (dd >> 9) & SYS_MAX;
            default: if (m_user) m_run = d[0];
         endcase
      end else begin
         if (s && !w && a == 2'd0 && !m_user) begin m_reached = 0; m_irq = 0; end
         if (t) begin
            if (!m_user) begin
               tm1 = (m_lim == 0) ? SYS_MAX : m_lim - 1;
               if (m_cnt >= tm1) begin m_cnt = '0; m_reached = 1; m_irq = 1; end
               else m_cnt = m_cnt + 1;
            end else if (m_run) begin
               if (m_cnt == USR_MAX) m_reached = 1;
               else begin
                  m_cnt = m_cnt + 1;
                  if (m_cnt == USR_MAX) m_reached = 1;
               end
            end
         end
      end
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one clock: drive at negedge, model update, compare after the edge
   task automatic step(input bit s, input bit w, input logic [1:0] a,
                       input logic [31:0] d, input bit t);
      bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d; tick = t; user_mode = um;
      model_update(s, w, a, d, t);
      @(posedge clk); #1;
      chk({cur_req, " irq"}, {31'b0, irq}, {31'b0, m_irq});
      chk({cur_req, " rdata"}, bus_rdata, model_read(a));
      @(negedge clk);
   endtask

   task automatic ticks(input int n, input logic [1:0] a);
      for (int i = 0; i < n; i++) step(0, 0, a, '0, 1);
   endtask

   initial begin
      #(5.0 * 100000);
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      m_cnt = '0; m_lim = '0; m_user = 0; m_reached = 0; m_irq = 0; m_run = 1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      cur_req = "R1";
      step(1, 0, 2'd3, '0, 0); chk("R1 running", bus_rdata, 32'h1);
      step(1, 0, 2'd1, '0, 0); chk("R1 count", bus_rdata, 32'h0);
      step(1, 0, 2'd0, '0, 0); chk("R1 limit", bus_rdata, 32'h0);
      chk("R1 irq", {31'b0, irq}, 32'h0);

      cur_req = "R3";
      step(1, 1, 2'd0, 32'(5 << 9), 0);
      step(0, 0, 2'd0, '0, 0); chk("R3 limit load", bus_rdata, 32'h0A00);
      cur_req = "R2";
      ticks(4, 2'd1); chk("R2 count 4", bus_rdata, 32'h0800); chk("R2 no irq", {31'b0, irq}, 0);
      ticks(1, 2'd1); chk("R2 wrap", bus_rdata, 32'h8000_0000); chk("R2 irq", {31'b0, irq}, 1);
      cur_req = "R4";
      step(1, 0, 2'd0, '0, 0); chk("R4 read ack irq", {31'b0, irq}, 0);
      step(0, 0, 2'd1, '0, 0); chk("R4 reached cleared", bus_rdata, 32'h0);
      cur_req = "R3";
      ticks(2, 2'd1);
      step(1, 1, 2'd2, 32'(8 << 9), 0);
      step(0, 0, 2'd1, '0, 0); chk("R3 keep count", bus_rdata, 32'h0400);
      ticks(6, 2'd1); chk("R3 new limit wrap", {31'b0, irq}, 1);
      step(1, 1, 2'd0, 32'(3 << 9), 0); chk("R3 write clears irq", {31'b0, irq}, 0);
      cur_req = "R2";
      step(1, 1, 2'd0, 32'h0, 0);
      ticks(20, 2'd1); chk("R2 free run", bus_rdata, 32'(20 << 9)); chk("R2 free no irq", {31'b0, irq}, 0);
      cur_req = "R5";
      step(1, 1, 2'd1, 32'hFFFF_FFFF, 0);
      step(1, 1, 2'd3, 32'h0, 0);
      step(0, 0, 2'd1, '0, 0); chk("R5 word1 ignored", bus_rdata, 32'(20 << 9));
      step(0, 0, 2'd3, '0, 0); chk("R5 word3 ignored", bus_rdata, 32'h1);
      cur_req = "R12";
      step(1, 1, 2'd2, 32'h0, 1);
      step(0, 0, 2'd1, '0, 0); chk("R12 write beats tick", bus_rdata, 32'(20 << 9));

      cur_req = "R10";
      step(1, 1, 2'd0, 32'(2 << 9), 0);
      ticks(2, 2'd1); chk("R10 irq before switch", {31'b0, irq}, 1);
      um = 1;
      step(0, 0, 2'd3, '0, 0); chk("R10 stopped", bus_rdata, 32'h0); chk("R10 irq low", {31'b0, irq}, 0);
      step(0, 0, 2'd0, '0, 0); chk("R10 reached kept", bus_rdata, 32'h8000_0000);
      cur_req = "R8";
      ticks(3, 2'd1); chk("R8 stopped ignores tick", bus_rdata, 32'h0);
      step(1, 1, 2'd3, 32'h1, 0);
      step(0, 0, 2'd3, '0, 0); chk("R8 started", bus_rdata, 32'h1);
      ticks(3, 2'd1); chk("R8 counts", bus_rdata, 32'(3 << 9));
      cur_req = "R7";
      step(1, 1, 2'd0, 32'h7FFF_FFFF, 0);
      step(1, 1, 2'd1, 32'hFFFF_FA00, 0);
      cur_req = "R6";
      step(0, 0, 2'd0, '0, 0); chk("R6 R7 high word", bus_rdata, 32'h7FFF_FFFF);
      step(0, 0, 2'd1, '0, 0); chk("R6 R7 low word", bus_rdata, 32'hFFFF_FA00);
      step(0, 0, 2'd2, '0, 0); chk("R6 word2 zero", bus_rdata, 32'h0);
      cur_req = "R9";
      ticks(2, 2'd0); chk("R9 reached max", bus_rdata, 32'hFFFF_FFFF);
      ticks(4, 2'd1); chk("R9 holds", bus_rdata, 32'hFFFF_FE00); chk("R9 no irq", {31'b0, irq}, 0);
      cur_req = "R8";
      step(1, 1, 2'd3, 32'h0, 0);
      cur_req = "R7";
      step(1, 1, 2'd1, 32'h0, 0);
      step(0, 0, 2'd0, '0, 0); chk("R7 reload clears reached", bus_rdata, 32'h7FFF_FFFF);
      cur_req = "R8";
      ticks(3, 2'd1); chk("R8 stop holds", bus_rdata, 32'h0);

      cur_req = "R12";
      um = 0;
      step(1, 1, 2'd3, 32'h0, 1); chk("R12 R11 running after leave", bus_rdata, 32'h1);
      cur_req = "R11";
      step(0, 0, 2'd1, '0, 0); chk("R11 count cleared", bus_rdata, 32'h0);
      cur_req = "R12";
      um = 1;
      step(1, 1, 2'd0, 32'h1234_5678, 0);
      step(0, 0, 2'd0, '0, 0); chk("R12 write lost on entry", bus_rdata, 32'h0);
      um = 0;
      step(0, 0, 2'd0, '0, 0); chk("R10 limit zeroed", bus_rdata, 32'h0);
      cur_req = "R2";
      step(1, 1, 2'd0, 32'(3 << 9), 0);
      ticks(7, 2'd1); chk("R2 second wrap count", bus_rdata, 32'h8000_0200);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule